// File: doc/BRIEF.md
# Current Sample Calibration Datapath

This block turns raw current-sense conversion results into calibrated signed 16-bit currents. It carries two independent streams. The fast stream takes a 24-bit raw sample and yields a reported current. It also yields a sign-extended 32-bit copy of that raw sample with no correction applied. The slow stream takes a 16-bit raw sample and yields the current used for charge integration. Each stream subtracts an offset, multiplies by a gain, divides by a fixed power of two, rounds, and clamps to the 16-bit signed range. The gain value sets the unit of one output LSB.

Both streams use valid/ready handshakes at input and output. A beat transfers on a clock edge where valid and ready are both high. Each stream is a two-stage pipeline that moves only as a whole. It advances when its output register is empty or the consumer takes the output. The input ready of a stream is that advance condition. Back-pressure from the output therefore reaches the input in the same cycle, and a stalled output holds its data unchanged. The two streams share no handshake, so a stall on one never stalls the other.

There are four calibration values: a gain and an offset for each stream. While reset is asserted they load from trim inputs. Afterwards they can be rewritten only while the configuration-update input is high. A sample takes the gain and offset in force on the edge where it is accepted.

Top module: `curr_cal_top`

## Requirements
- R1: Fast output = round((raw24 − fast_offset) × fast_gain / 8192). Raw24, offset and gain are two's-complement signed. Ties round away from zero.
- R2: Slow output = round((raw16 − slow_offset/256) × slow_gain / 32). This is computed exactly as ((raw16×256 − slow_offset) × slow_gain) / 8192, with ties rounded away from zero.
- R3: A rounded result above +32767 gives 32767 (0x7FFF). A result below −32768 gives −32768 (0x8000).
- R4: fast_out_raw carries, in the same beat as fast_out_cur, the accepted raw24 value in bits 23:0. Bits 31:24 repeat bit 23. No offset or gain is applied.
- R5: With the output not stalled, a beat accepted on edge k shows out_valid high after edge k+1. in_ready is high exactly when out_valid is low or out_ready is high.
- R6: While out_valid is high and out_ready is low, out_valid and the output data stay unchanged and in_ready is low.
- R7: During reset both out_valid signals are low. After reset, the calibration values equal the trim inputs.
- R8: Writes while cfg_update is low have no effect. A write with cfg_update high replaces one value, chosen by cfg_wr_sel: 0 = fast gain, 1 = fast offset, 2 = slow gain, 3 = slow offset. Samples accepted from the next edge on use the new value.
- R9: The fast and slow streams run independently. A beat or a stall on one does not change the other's valid, ready or data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (also loads trim values) |
| cfg_update | input | 1 | Enables calibration writes when high |
| cfg_wr_en | input | 1 | Write strobe for a calibration value |
| cfg_wr_sel | input | 2 | Selects the value written (see R8) |
| cfg_wr_data | input | 16 | Signed value to write |
| trim_fast_gain | input | 16 | Reset default of fast gain |
| trim_fast_ofs | input | 16 | Reset default of fast offset |
| trim_slow_gain | input | 16 | Reset default of slow gain |
| trim_slow_ofs | input | 16 | Reset default of slow offset |
| fast_in_valid | input | 1 | Fast raw sample valid |
| fast_in_ready | output | 1 | Fast stream can accept |
| fast_in_raw | input | 24 | Fast raw sample, signed |
| fast_out_valid | output | 1 | Fast result valid |
| fast_out_ready | input | 1 | Consumer takes fast result |
| fast_out_cur | output | 16 | Calibrated fast current, signed |
| fast_out_raw | output | 32 | Sign-extended uncorrected fast sample |
| slow_in_valid | input | 1 | Slow raw sample valid |
| slow_in_ready | output | 1 | Slow stream can accept |
| slow_in_raw | input | 16 | Slow raw sample, signed |
| slow_out_valid | output | 1 | Slow result valid |
| slow_out_ready | input | 1 | Consumer takes slow result |
| slow_out_cur | output | 16 | Calibrated slow current, signed |

## Verification
The arithmetic is tried first with unity gain and zero offset at raw values that sit exactly on, just below and just past a half step. This separates round-half-away-from-zero from truncation and from round-half-up. Extreme raw values with large gains of both signs are used next. They separate correct clamping from wrap-around, and they show whether bits 31:24 of the raw copy follow bit 23. Long runs of random samples are then applied, first with the consumer always ready and then with random stalls on each stream. These runs show the two-cycle latency, the hold of stalled data, and the independence of the streams. Writes of calibration values are attempted with the update flag low and then high, and each attempt is followed by a sample whose result shows whether the value took effect.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int CAL_W = 16;

  typedef enum logic [1:0] {
    SEL_FAST_GAIN = 2'd0,
    SEL_FAST_OFS  = 2'd1,
    SEL_SLOW_GAIN = 2'd2,
    SEL_SLOW_OFS  = 2'd3
  } cal_sel_e;

  typedef struct packed {
    logic signed [CAL_W-1:0] gain;
    logic signed [CAL_W-1:0] ofs;
  } path_cfg_t;
endpackage

// File: rtl/cal_cfg_regs.sv
module cal_cfg_regs
  import cal_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_update,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CAL_W-1:0] wr_data,
  input  path_cfg_t        trim_fast,
  input  path_cfg_t        trim_slow,
  output path_cfg_t        fast_cfg,
  output path_cfg_t        slow_cfg
);
  path_cfg_t fast_q, slow_q;
  logic      wr_ok;
  cal_sel_e  sel;

  assign wr_ok = wr_en && cfg_update;
  assign sel   = cal_sel_e'(wr_sel);

  // Synchronous load so the reset value may come from the trim inputs.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fast_q <= trim_fast;
      slow_q <= trim_slow;
    end else if (wr_ok) begin
      case (sel)
        SEL_FAST_GAIN: fast_q.gain <= wr_data;
        SEL_FAST_OFS:  fast_q.ofs  <= wr_data;
        SEL_SLOW_GAIN: slow_q.gain <= wr_data;
        default:       slow_q.ofs  <= wr_data;
      endcase
    end
  end

  assign fast_cfg = fast_q;
  assign slow_cfg = slow_q;

  assert_cfg_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_update |=> ($stable(fast_q) && $stable(slow_q)));
endmodule

// File: rtl/cal_round_sat.sv
module cal_round_sat #(
  parameter int IN_W  = 41,
  parameter int SH    = 13,
  parameter int OUT_W = 16
) (
  input  logic signed [IN_W-1:0]  prod,
  output logic signed [OUT_W-1:0] res
);
  localparam int MW = IN_W + 1;
  localparam logic [MW-1:0] HALF    = MW'(1) << (SH - 1);
  localparam logic [MW-1:0] POS_LIM = (MW'(1) << (OUT_W - 1)) - MW'(1);
  localparam logic [MW-1:0] NEG_LIM = MW'(1) << (OUT_W - 1);
  localparam logic [OUT_W-1:0] OUT_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] OUT_MIN = {1'b1, {(OUT_W-1){1'b0}}};

  logic          neg;
  logic [MW-1:0] ext, mag, rnd, rnd_neg;

  always_comb begin
    neg     = prod[IN_W-1];
    ext     = {prod[IN_W-1], prod};
    mag     = neg ? (~ext + MW'(1)) : ext;
    rnd     = (mag + HALF) >> SH;
    rnd_neg = ~rnd + MW'(1);
    if (neg) begin
      res = (rnd >= NEG_LIM) ? OUT_MIN : rnd_neg[OUT_W-1:0];
    end else begin
      res = (rnd > POS_LIM) ? OUT_MAX : rnd[OUT_W-1:0];
    end
  end
endmodule

// File: rtl/cal_path.sv
module cal_path #(
  parameter int RAW_W  = 24,
  parameter int PRE_SH = 0,
  parameter int DIV_SH = 13,
  parameter int OFS_W  = 16,
  parameter int GAIN_W = 16,
  parameter int OUT_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [RAW_W-1:0]  in_raw,
  input  logic signed [OFS_W-1:0]  ofs,
  input  logic signed [GAIN_W-1:0] gain,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic signed [OUT_W-1:0]  out_data
);
  localparam int SH_W   = RAW_W + PRE_SH;
  localparam int DIFF_W = ((SH_W > OFS_W) ? SH_W : OFS_W) + 1;
  localparam int PROD_W = DIFF_W + GAIN_W;

  logic                      adv;
  logic signed [DIFF_W-1:0]  raw_ext, ofs_ext, diff;
  logic                      s1_valid;
  logic signed [DIFF_W-1:0]  s1_diff;
  logic signed [GAIN_W-1:0]  s1_gain;
  logic signed [PROD_W-1:0]  prod;
  logic signed [OUT_W-1:0]   res;
  logic                      out_valid_q, s2_neg, s2_pos;
  logic signed [OUT_W-1:0]   out_q;

  assign adv      = !out_valid_q || out_ready;
  assign in_ready = adv;

  // Offset lives in the same fixed-point grid as the shifted raw sample.
  assign raw_ext = DIFF_W'(in_raw) <<< PRE_SH;
  assign ofs_ext = DIFF_W'(ofs);
  assign diff    = raw_ext - ofs_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_diff  <= '0;
      s1_gain  <= '0;
    end else if (adv) begin
      s1_valid <= in_valid;
      s1_diff  <= diff;
      s1_gain  <= gain;
    end
  end

  assign prod = PROD_W'(s1_diff) * PROD_W'(s1_gain);

  cal_round_sat #(.IN_W(PROD_W), .SH(DIV_SH), .OUT_W(OUT_W)) u_rnd (
    .prod (prod),
    .res  (res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_q <= 1'b0;
      out_q       <= '0;
      s2_neg      <= 1'b0;
      s2_pos      <= 1'b0;
    end else if (adv) begin
      out_valid_q <= s1_valid;
      out_q       <= res;
      s2_neg      <= prod < 0;
      s2_pos      <= prod > 0;
    end
  end

  assign out_valid = out_valid_q;
  assign out_data  = out_q;

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_two_stage_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && in_ready) |=> out_valid);

  assert_sign_neg_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && s2_neg) |-> (out_data <= 0));

  assert_sign_pos_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && s2_pos) |-> (out_data >= 0));
endmodule

// File: rtl/cal_raw_tap.sv
module cal_raw_tap #(
  parameter int RAW_W = 24,
  parameter int EXT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [RAW_W-1:0] in_raw,
  output logic [EXT_W-1:0] out_ext
);
  localparam int PAD_W = EXT_W - RAW_W;

  logic [RAW_W-1:0] s1_raw;
  logic [EXT_W-1:0] out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_raw <= '0;
      out_q  <= '0;
    end else if (adv) begin
      s1_raw <= in_raw;
      out_q  <= {{PAD_W{s1_raw[RAW_W-1]}}, s1_raw};
    end
  end

  assign out_ext = out_q;
endmodule

// File: rtl/curr_cal_top.sv
module curr_cal_top
  import cal_pkg::*;
#(
  parameter int FAST_RAW_W    = 24,
  parameter int SLOW_RAW_W    = 16,
  parameter int OUT_W         = 16,
  parameter int RAW_EXT_W     = 32,
  parameter int FAST_DIV_SH   = 13,
  parameter int SLOW_OFS_FRAC = 8,
  parameter int SLOW_DIV_SH   = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_update,
  input  logic                  cfg_wr_en,
  input  logic [1:0]            cfg_wr_sel,
  input  logic [CAL_W-1:0]      cfg_wr_data,
  input  logic [CAL_W-1:0]      trim_fast_gain,
  input  logic [CAL_W-1:0]      trim_fast_ofs,
  input  logic [CAL_W-1:0]      trim_slow_gain,
  input  logic [CAL_W-1:0]      trim_slow_ofs,
  input  logic                  fast_in_valid,
  output logic                  fast_in_ready,
  input  logic [FAST_RAW_W-1:0] fast_in_raw,
  output logic                  fast_out_valid,
  input  logic                  fast_out_ready,
  output logic [OUT_W-1:0]      fast_out_cur,
  output logic [RAW_EXT_W-1:0]  fast_out_raw,
  input  logic                  slow_in_valid,
  output logic                  slow_in_ready,
  input  logic [SLOW_RAW_W-1:0] slow_in_raw,
  output logic                  slow_out_valid,
  input  logic                  slow_out_ready,
  output logic [OUT_W-1:0]      slow_out_cur
);
  localparam int SLOW_SH_TOTAL = SLOW_OFS_FRAC + SLOW_DIV_SH;

  path_cfg_t trim_fast, trim_slow, fast_cfg, slow_cfg;

  assign trim_fast = '{gain: trim_fast_gain, ofs: trim_fast_ofs};
  assign trim_slow = '{gain: trim_slow_gain, ofs: trim_slow_ofs};

  cal_cfg_regs u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_update (cfg_update),
    .wr_en      (cfg_wr_en),
    .wr_sel     (cfg_wr_sel),
    .wr_data    (cfg_wr_data),
    .trim_fast  (trim_fast),
    .trim_slow  (trim_slow),
    .fast_cfg   (fast_cfg),
    .slow_cfg   (slow_cfg)
  );

  cal_path #(
    .RAW_W(FAST_RAW_W), .PRE_SH(0), .DIV_SH(FAST_DIV_SH),
    .OFS_W(CAL_W), .GAIN_W(CAL_W), .OUT_W(OUT_W)
  ) u_fast (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (fast_in_valid),
    .in_ready  (fast_in_ready),
    .in_raw    (fast_in_raw),
    .ofs       (fast_cfg.ofs),
    .gain      (fast_cfg.gain),
    .out_valid (fast_out_valid),
    .out_ready (fast_out_ready),
    .out_data  (fast_out_cur)
  );

  cal_raw_tap #(.RAW_W(FAST_RAW_W), .EXT_W(RAW_EXT_W)) u_tap (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (fast_in_ready),
    .in_raw  (fast_in_raw),
    .out_ext (fast_out_raw)
  );

  cal_path #(
    .RAW_W(SLOW_RAW_W), .PRE_SH(SLOW_OFS_FRAC), .DIV_SH(SLOW_SH_TOTAL),
    .OFS_W(CAL_W), .GAIN_W(CAL_W), .OUT_W(OUT_W)
  ) u_slow (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (slow_in_valid),
    .in_ready  (slow_in_ready),
    .in_raw    (slow_in_raw),
    .ofs       (slow_cfg.ofs),
    .gain      (slow_cfg.gain),
    .out_valid (slow_out_valid),
    .out_ready (slow_out_ready),
    .out_data  (slow_out_cur)
  );

  assert_raw_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fast_out_valid |-> (fast_out_raw[RAW_EXT_W-1:FAST_RAW_W] ==
                        {(RAW_EXT_W-FAST_RAW_W){fast_out_raw[FAST_RAW_W-1]}}));
endmodule

// File: tb/test_curr_cal_top.sv
`timescale 1ns/100ps
module test_curr_cal_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_update = 1'b0, cfg_wr_en = 1'b0;
  logic [1:0] cfg_wr_sel = '0;
  logic [15:0] cfg_wr_data = '0;
  logic [15:0] trim_fast_gain = 16'd4000, trim_fast_ofs = 16'hFFCE;
  logic [15:0] trim_slow_gain = 16'd900,  trim_slow_ofs = 16'd300;
  logic fast_in_valid = 1'b0, fast_out_ready = 1'b0;
  logic [23:0] fast_in_raw = '0;
  logic slow_in_valid = 1'b0, slow_out_ready = 1'b0;
  logic [15:0] slow_in_raw = '0;
  logic fast_in_ready, fast_out_valid, slow_in_ready, slow_out_valid;
  logic [15:0] fast_out_cur, slow_out_cur;
  logic [31:0] fast_out_raw;

  always #2.5 clk = ~clk;

  curr_cal_top i_curr_cal_top (.*);

  int total = 0, bad = 0;
  bit done = 0;

  // reference state
  longint mg [4];
  bit     m_f1v, m_fov, m_s1v, m_sov;
  longint m_f1c, m_f1r, m_foc, m_for, m_s1c, m_soc;
  bit     fp_v, sp_v;
  logic [23:0] fp_raw;
  logic [15:0] sp_raw;

  function automatic longint rnd_sat(longint p);
    longint r;
    r = (p >= 0) ? (p + 4096) / 8192 : -((-p + 4096) / 8192);
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  function automatic longint ref_fast(longint raw);
    return rnd_sat((raw - mg[1]) * mg[0]);
  endfunction

  function automatic longint ref_slow(longint raw);
    return rnd_sat((raw * 256 - mg[3]) * mg[2]);
  endfunction

  task automatic chk(string tag, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(string tag, logic we, logic up, logic [1:0] sel,
                      logic [15:0] d, logic frdy, logic srdy);
    bit fadv, sadv;
    @(negedge clk);
    chk(tag, "fast valid", fast_out_valid, m_fov);
    if (m_fov) begin
      chk(tag, "fast cur", longint'($signed(fast_out_cur)), m_foc);
      chk(tag, "fast raw", longint'($signed(fast_out_raw)), m_for);
    end
    chk(tag, "slow valid", slow_out_valid, m_sov);
    if (m_sov) chk(tag, "slow cur", longint'($signed(slow_out_cur)), m_soc);
    fast_in_valid = fp_v; fast_in_raw = fp_raw; fast_out_ready = frdy;
    slow_in_valid = sp_v; slow_in_raw = sp_raw; slow_out_ready = srdy;
    cfg_wr_en = we; cfg_update = up; cfg_wr_sel = sel; cfg_wr_data = d;
    #1;
    chk(tag, "fast ready", fast_in_ready, !m_fov || frdy);
    chk(tag, "slow ready", slow_in_ready, !m_sov || srdy);
    fadv = !m_fov || frdy;
    sadv = !m_sov || srdy;
    if (fadv) begin
      m_fov = m_f1v; m_foc = m_f1c; m_for = m_f1r;
      m_f1v = fp_v;
      if (fp_v) begin
        m_f1r = longint'($signed(fp_raw));
        m_f1c = ref_fast(m_f1r);
        fp_v = 0;
      end
    end
    if (sadv) begin
      m_sov = m_s1v; m_soc = m_s1c;
      m_s1v = sp_v;
      if (sp_v) begin
        m_s1c = ref_slow(longint'($signed(sp_raw)));
        sp_v = 0;
      end
    end
    if (up && we) mg[sel] = longint'($signed(d));
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) step(tag, 0, 0, 2'd0, 16'd0, 1, 1);
  endtask

  task automatic send_fast(string tag, logic [23:0] raw);
    fp_v = 1; fp_raw = raw;
    while (fp_v) step(tag, 0, 0, 2'd0, 16'd0, 1, 1);
    idle(tag, 3);
  endtask

  task automatic send_slow(string tag, logic [15:0] raw);
    sp_v = 1; sp_raw = raw;
    while (sp_v) step(tag, 0, 0, 2'd0, 16'd0, 1, 1);
    idle(tag, 3);
  endtask

  task automatic wcfg(string tag, logic up, logic [1:0] sel, logic [15:0] d);
    step(tag, 1, up, sel, d, 1, 1);
  endtask

  task automatic rand_run(string tag, int n, bit stall_f, bit stall_s, bit use_f, bit use_s);
    for (int i = 0; i < n; i++) begin
      if (use_f && !fp_v && ($urandom % 3 != 0)) begin
        fp_v = 1;
        fp_raw = 24'($urandom);
        if ($urandom % 2 == 0) fp_raw = 24'($signed(fp_raw) >>> ($urandom % 20));
      end
      if (use_s && !sp_v && ($urandom % 3 != 0)) begin
        sp_v = 1;
        sp_raw = 16'($urandom);
        if ($urandom % 2 == 0) sp_raw = 16'($signed(sp_raw) >>> ($urandom % 14));
      end
      step(tag, 0, 0, 2'd0, 16'd0,
           stall_f ? ($urandom % 2 == 0) : 1'b1,
           stall_s ? ($urandom % 3 != 0) : 1'b1);
    end
    idle(tag, 4);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    mg[0] = longint'($signed(trim_fast_gain)); mg[1] = longint'($signed(trim_fast_ofs));
    mg[2] = longint'($signed(trim_slow_gain)); mg[3] = longint'($signed(trim_slow_ofs));
    fp_v = 0; sp_v = 0; fp_raw = '0; sp_raw = '0;
    m_f1v = 0; m_fov = 0; m_s1v = 0; m_sov = 0;
    m_f1c = 0; m_f1r = 0; m_foc = 0; m_for = 0; m_s1c = 0; m_soc = 0;
    // R7: outputs idle during reset, trims loaded
    repeat (5) @(negedge clk);
    chk("R7", "fast valid in reset", fast_out_valid, 0);
    chk("R7", "slow valid in reset", slow_out_valid, 0);
    rst_n = 1'b1;
    send_fast("R7", 24'd123456);
    send_slow("R7", 16'd1000);

    // R1: rounding at half steps with unity gain, zero offset
    wcfg("R1", 1, 2'd0, 16'd1);
    wcfg("R1", 1, 2'd1, 16'd0);
    send_fast("R1", 24'd4096);
    send_fast("R1", 24'd4095);
    send_fast("R1", 24'hFFF000);
    send_fast("R1", 24'hFFF001);
    send_fast("R1", 24'd12288);
    send_fast("R1", 24'hFFD000);
    // R2: slow path with fractional offset
    wcfg("R2", 1, 2'd2, 16'd1);
    wcfg("R2", 1, 2'd3, 16'd128);
    send_slow("R2", 16'd16);
    send_slow("R2", 16'd17);
    wcfg("R2", 1, 2'd3, 16'hFF80);
    send_slow("R2", 16'hFFF0);
    send_slow("R2", 16'd0);

    // R3: clamp both directions
    wcfg("R3", 1, 2'd0, 16'h7FFF);
    wcfg("R3", 1, 2'd1, 16'h8000);
    send_fast("R3", 24'h7FFFFF);
    send_fast("R3", 24'h800000);
    wcfg("R3", 1, 2'd0, 16'h8000);
    send_fast("R3", 24'h7FFFFF);
    wcfg("R3", 1, 2'd2, 16'h7FFF);
    send_slow("R3", 16'h8000);
    send_slow("R3", 16'h7FFF);

    // R4: raw copy sign extension
    send_fast("R4", 24'h800001);
    send_fast("R4", 24'h7FFFFE);

    // R8: writes ignored with update low, applied with it high
    wcfg("R8", 1, 2'd0, 16'd10);
    wcfg("R8", 1, 2'd1, 16'd0);
    wcfg("R8", 0, 2'd0, 16'd777);
    wcfg("R8", 0, 2'd1, 16'd555);
    send_fast("R8", 24'd81920);
    wcfg("R8", 0, 2'd2, 16'd3);
    send_slow("R8", 16'd500);
    wcfg("R8", 1, 2'd0, 16'hFFF6);
    send_fast("R8", 24'd81920);

    // R5 streaming, R6 back-pressure, R9 independence
    wcfg("R5", 1, 2'd0, 16'd4000);
    wcfg("R5", 1, 2'd1, 16'hFFCE);
    wcfg("R5", 1, 2'd2, 16'd900);
    wcfg("R5", 1, 2'd3, 16'd300);
    rand_run("R5", 3000, 0, 0, 1, 1);
    rand_run("R6", 4000, 1, 1, 1, 1);
    rand_run("R9", 2000, 1, 0, 1, 0);
    rand_run("R9", 2000, 0, 1, 0, 1);
    rand_run("R9", 2000, 1, 0, 0, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule